// File: doc/BRIEF.md
# Protected SRAM Bus Interface Unit

This block is a bus slave that fronts an on-chip static memory array. Bus masters issue read and write requests of 8, 16 or 32 bits; each request carries a write flag, an instruction-fetch flag and a privilege flag. The array is a run of equal blocks that fill one unbroken address range starting at zero. The last block may be only partly filled, and the space beyond the filled part is treated as unimplemented.

Every block has three protection attributes, held in a module control register. The first refuses writes. The second refuses instruction fetches. The third refuses user-mode accesses. The same register holds a mode bit that switches the unit from single-cycle responses to a slower two-cycle response, which saves power. A refused, misaligned or unimplemented access gets an error response with zero data and leaves both the memory and the control register unchanged.

The handshake is a valid/ready request port and a registered one-cycle response strobe. In single-cycle mode a request can be accepted on every clock, so back-to-back accesses run as a pipeline. In two-cycle mode a new request is accepted in the same cycle that the previous response is presented.

Top module: `sram_biu_top`

## Requirements
- R1: In single-cycle mode (control bit 0 clear), `reqReady` stays high, and a request accepted at a clock edge has `rspValid` high for exactly the following cycle. Requests offered on consecutive cycles are each accepted and answered in order, one response per cycle.
- R2: Size code 0 is a byte access, 1 is a half-word access and 2 is a word access. Byte lanes are little-endian: the byte at address a sits in bits 8*(a mod 4) of its word. Write data is taken from the low bits of `reqWdata`. Read data is returned right-justified and zero-extended. A write returns zero data.
- R3: Block index is address / BLOCK_BYTES. Addresses at or above IMPL_BYTES, including the unused top of a partial last block, get an error.
- R4: When a block's read-only bit (control bit 8+i) is set, writes to that block get an error. Reads and fetches are unaffected.
- R5: When a block's data-only bit (control bit 16+i) is set, instruction-fetch reads (`reqFetch`=1, `reqWrite`=0) from it get an error. Data reads and writes are unaffected.
- R6: When a block's supervisor bit (control bit 24+i) is set, user accesses (`reqSuper`=0) to it get an error.
- R7: In two-cycle mode (control bit 0 set), the response to an accepted request comes two cycles after acceptance. Both `reqReady` and `rspValid` are low in the cycle between. `reqReady` is high again in the response cycle.
- R8: An error response has `rspErr` and `rspValid` high together for one cycle and `rspRdata` zero. It leaves the memory and the control register unchanged.
- R9: A half-word at an odd address, a word whose address is not a multiple of 4, and size code 3 each get an error.
- R10: With `reqCfg`=1 the access targets the control register and the address is ignored. Only word size is allowed. Reads are allowed in either privilege mode. Writes need `reqSuper`=1, or they get an error. Undefined bits read as zero, and the register resets to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be accepted this cycle |
| reqCfg | input | 1 | Target the control register instead of the array |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqFetch | input | 1 | Read is an instruction fetch |
| reqSuper | input | 1 | Supervisor privilege |
| reqSize | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | 32 | Write data, right-justified |
| rspValid | output | 1 | Response strobe |
| rspErr | output | 1 | Access refused |
| rspRdata | output | 32 | Read data, right-justified |

## Verification
The bench uses a small configuration: three 64-byte blocks with the last one half filled. Every implemented address is read at every legal size after mixed word, half and byte writes. This separates lane placement and zero-extension faults from addressing faults. Every address past the filled part is probed to locate the unimplemented boundary exactly, and every size/offset pairing is tried to isolate the alignment rules. For each block, all eight combinations of protection attributes are crossed with all eight write/fetch/privilege request kinds. Each refused write is followed by a read-back, so a wrong attribute bit, a wrong block decode or a write that leaks through shows up on its own. Latency is measured on every access in both modes, and a back-to-back burst shows whether accesses are pipelined.

// File: rtl/sram_biu_pkg.sv
package sram_biu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } accSizeE;

  // strobes from sequencing control to the datapath
  typedef struct packed {
    logic holdEn;   // capture the incoming request
    logic useHold;  // execute from the captured copy
    logic execEn;   // perform the access and register a response
  } seqStrobeT;

  // control register field positions
  localparam int CTRL_MODE_BIT = 0;
  localparam int CTRL_RO_LSB   = 8;
  localparam int CTRL_DO_LSB   = 16;
  localparam int CTRL_SUP_LSB  = 24;

endpackage

// File: rtl/sram_biu_ctrl.sv
module sram_biu_ctrl
  import sram_biu_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      reqValid,
  input  logic      modeTwo,
  output logic      reqReady,
  output seqStrobeT strobe
);

  logic waitCyc;
  logic accept;

  assign reqReady = ~waitCyc;
  assign accept   = reqValid & ~waitCyc;

  always_comb begin
    strobe.holdEn  = accept;
    strobe.useHold = waitCyc;
    strobe.execEn  = (accept & ~modeTwo) | waitCyc;
  end

  always_ff @(posedge clk) begin
    if (rst) waitCyc <= 1'b0;
    else     waitCyc <= accept & modeTwo;
  end

endmodule

// File: rtl/sram_biu_guard.sv
module sram_biu_guard
  import sram_biu_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BLOCK_BYTES = 4096,
  parameter int NUM_BLOCKS  = 2,
  parameter int IMPL_BYTES  = 6144
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic [1:0]            size,
  input  logic                  isCfg,
  input  logic                  isWrite,
  input  logic                  isFetch,
  input  logic                  isSuper,
  input  logic [NUM_BLOCKS-1:0] roBits,
  input  logic [NUM_BLOCKS-1:0] doBits,
  input  logic [NUM_BLOCKS-1:0] supBits,
  output logic                  accErr
);

  localparam int BLOCK_SHIFT = $clog2(BLOCK_BYTES);
  localparam logic [ADDR_W:0] IMPL_LIM = (ADDR_W+1)'(IMPL_BYTES);

  logic [ADDR_W-1:0]     blkFull;
  logic [NUM_BLOCKS-1:0] blkHit;
  logic                  implemented;
  logic                  misAlign;
  logic                  roHit, doHit, supHit;

  assign blkFull     = addr >> BLOCK_SHIFT;
  assign implemented = {1'b0, addr} < IMPL_LIM;

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
    assign blkHit[g] = implemented && (blkFull == ADDR_W'(g));
  end

  assign roHit  = |(blkHit & roBits);
  assign doHit  = |(blkHit & doBits);
  assign supHit = |(blkHit & supBits);

  always_comb begin
    case (accSizeE'(size))
      SZ_BYTE: misAlign = 1'b0;
      SZ_HALF: misAlign = addr[0];
      SZ_WORD: misAlign = |addr[1:0];
      default: misAlign = 1'b1;
    endcase
  end

  always_comb begin
    if (isCfg) begin
      accErr = (accSizeE'(size) != SZ_WORD) || (isWrite && !isSuper);
    end else begin
      accErr = misAlign || !implemented
            || (isWrite && roHit)
            || (!isWrite && isFetch && doHit)
            || (!isSuper && supHit);
    end
  end

endmodule

// File: rtl/sram_biu_dpath.sv
module sram_biu_dpath
  import sram_biu_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BLOCK_BYTES = 4096,
  parameter int NUM_BLOCKS  = 2,
  parameter int IMPL_BYTES  = 6144
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobeT         strobe,
  input  logic              inCfg,
  input  logic              inWrite,
  input  logic              inFetch,
  input  logic              inSuper,
  input  logic [1:0]        inSize,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [31:0]       inWdata,
  output logic              modeTwo,
  output logic              rspValid,
  output logic              rspErr,
  output logic [31:0]       rspRdata
);

  localparam int WORDS  = IMPL_BYTES / 4;
  localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [31:0] BLK_MASK  = 32'((64'd1 << NUM_BLOCKS) - 64'd1);
  localparam logic [31:0] CTRL_MASK = (32'd1 << CTRL_MODE_BIT)
                                    | (BLK_MASK << CTRL_RO_LSB)
                                    | (BLK_MASK << CTRL_DO_LSB)
                                    | (BLK_MASK << CTRL_SUP_LSB);

  // captured request for the two-cycle path
  logic              hCfg, hWrite, hFetch, hSuper;
  logic [1:0]        hSize;
  logic [ADDR_W-1:0] hAddr;
  logic [31:0]       hWdata;

  // request being executed
  logic              sCfg, sWrite, sFetch, sSuper;
  logic [1:0]        sSize;
  logic [ADDR_W-1:0] sAddr;
  logic [31:0]       sWdata;

  logic [31:0]       ctrlReg;
  logic              accErr;
  logic [1:0]        lane;
  logic [WIDX_W-1:0] wIdx;
  logic [3:0]        byteEn;
  logic [31:0]       wLane;
  logic              memWe, cfgWe;
  logic [31:0]       memWord, rdShift, rdVal;
  logic [31:0]       memArr [WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      hCfg <= 1'b0; hWrite <= 1'b0; hFetch <= 1'b0; hSuper <= 1'b0;
      hSize <= 2'd0; hAddr <= '0; hWdata <= '0;
    end else if (strobe.holdEn) begin
      hCfg <= inCfg; hWrite <= inWrite; hFetch <= inFetch; hSuper <= inSuper;
      hSize <= inSize; hAddr <= inAddr; hWdata <= inWdata;
    end
  end

  always_comb begin
    if (strobe.useHold) begin
      sCfg = hCfg; sWrite = hWrite; sFetch = hFetch; sSuper = hSuper;
      sSize = hSize; sAddr = hAddr; sWdata = hWdata;
    end else begin
      sCfg = inCfg; sWrite = inWrite; sFetch = inFetch; sSuper = inSuper;
      sSize = inSize; sAddr = inAddr; sWdata = inWdata;
    end
  end

  sram_biu_guard #(
    .ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES),
    .NUM_BLOCKS(NUM_BLOCKS), .IMPL_BYTES(IMPL_BYTES)
  ) i_guard (
    .addr   (sAddr),
    .size   (sSize),
    .isCfg  (sCfg),
    .isWrite(sWrite),
    .isFetch(sFetch),
    .isSuper(sSuper),
    .roBits (ctrlReg[CTRL_RO_LSB  +: NUM_BLOCKS]),
    .doBits (ctrlReg[CTRL_DO_LSB  +: NUM_BLOCKS]),
    .supBits(ctrlReg[CTRL_SUP_LSB +: NUM_BLOCKS]),
    .accErr (accErr)
  );

  assign modeTwo = ctrlReg[CTRL_MODE_BIT];
  assign lane    = sAddr[1:0];
  assign wIdx    = sAddr[WIDX_W+1:2];
  assign memWe   = strobe.execEn & ~accErr & ~sCfg & sWrite;
  assign cfgWe   = strobe.execEn & ~accErr &  sCfg & sWrite;

  always_comb begin
    case (accSizeE'(sSize))
      SZ_BYTE: begin byteEn = 4'b0001 << lane; wLane = {4{sWdata[7:0]}}; end
      SZ_HALF: begin byteEn = lane[1] ? 4'b1100 : 4'b0011; wLane = {2{sWdata[15:0]}}; end
      default: begin byteEn = 4'b1111; wLane = sWdata; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (memWe) begin
      for (int b = 0; b < 4; b++) begin
        if (byteEn[b]) memArr[wIdx][8*b +: 8] <= wLane[8*b +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        ctrlReg <= '0;
    else if (cfgWe) ctrlReg <= sWdata & CTRL_MASK;
  end

  assign memWord = memArr[wIdx];
  assign rdShift = memWord >> {lane, 3'b000};

  always_comb begin
    case (accSizeE'(sSize))
      SZ_BYTE: rdVal = {24'd0, rdShift[7:0]};
      SZ_HALF: rdVal = {16'd0, rdShift[15:0]};
      default: rdVal = memWord;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= strobe.execEn;
      rspErr   <= strobe.execEn & accErr;
      if (strobe.execEn && !accErr && !sWrite) rspRdata <= sCfg ? ctrlReg : rdVal;
      else                                     rspRdata <= '0;
    end
  end

endmodule

// File: rtl/sram_biu_top.sv
module sram_biu_top
  import sram_biu_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BLOCK_BYTES = 4096,
  parameter int NUM_BLOCKS  = 2,
  parameter int IMPL_BYTES  = 6144
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqCfg,
  input  logic              reqWrite,
  input  logic              reqFetch,
  input  logic              reqSuper,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic              rspValid,
  output logic              rspErr,
  output logic [31:0]       rspRdata
);

  seqStrobeT strobe;
  logic      modeTwo;
  logic      waitCyc;

  assign waitCyc = strobe.useHold;

  sram_biu_ctrl i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .reqValid(reqValid),
    .modeTwo (modeTwo),
    .reqReady(reqReady),
    .strobe  (strobe)
  );

  sram_biu_dpath #(
    .ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES),
    .NUM_BLOCKS(NUM_BLOCKS), .IMPL_BYTES(IMPL_BYTES)
  ) i_dpath (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .inCfg   (reqCfg),
    .inWrite (reqWrite),
    .inFetch (reqFetch),
    .inSuper (reqSuper),
    .inSize  (reqSize),
    .inAddr  (reqAddr),
    .inWdata (reqWdata),
    .modeTwo (modeTwo),
    .rspValid(rspValid),
    .rspErr  (rspErr),
    .rspRdata(rspRdata)
  );

endmodule

// File: rtl/sram_biu_chk.sv
module sram_biu_chk (
  input logic        clk,
  input logic        rst,
  input logic        reqValid,
  input logic        reqReady,
  input logic        reqCfg,
  input logic        reqWrite,
  input logic        reqSuper,
  input logic        rspValid,
  input logic        rspErr,
  input logic [31:0] rspRdata,
  input logic        modeTwo,
  input logic        waitCyc
);

  // R1
  fast_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady && !modeTwo) |=> rspValid);

  // R1
  rsp_origin_chk: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> ($past(reqValid && reqReady && !modeTwo) || $past(waitCyc)));

  // R7
  slow_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady && modeTwo) |=> (!rspValid && !reqReady));

  // R7
  slow_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady && modeTwo) |=> ##1 (rspValid && reqReady));

  // R8
  err_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rspErr |-> rspValid);

  // R8
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rspErr |-> (rspRdata == 32'd0));

  // R10
  user_cfg_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady && !modeTwo && reqCfg && reqWrite && !reqSuper) |=> rspErr);

endmodule

bind sram_biu_top sram_biu_chk i_chk (
  .clk     (clk),
  .rst     (rst),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .reqCfg  (reqCfg),
  .reqWrite(reqWrite),
  .reqSuper(reqSuper),
  .rspValid(rspValid),
  .rspErr  (rspErr),
  .rspRdata(rspRdata),
  .modeTwo (modeTwo),
  .waitCyc (waitCyc)
);

// File: tb/test_sram_biu_top.sv
`timescale 1ns/1ps
module test_sram_biu_top;

  localparam int AW = 10;
  localparam int BB = 64;
  localparam int NB = 3;
  localparam int IB = 160;
  localparam logic [31:0] MASK = 32'h0707_0701;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reqValid = 1'b0, reqCfg = 1'b0, reqWrite = 1'b0, reqFetch = 1'b0, reqSuper = 1'b0;
  logic [1:0]    reqSize = 2'd0;
  logic [AW-1:0] reqAddr = '0;
  logic [31:0]   reqWdata = '0;
  logic          reqReady, rspValid, rspErr;
  logic [31:0]   rspRdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0]  model [IB];
  logic [31:0] ctrlM = 32'd0;

  always #4 clk = ~clk;

  sram_biu_top #(.ADDR_W(AW), .BLOCK_BYTES(BB), .NUM_BLOCKS(NB), .IMPL_BYTES(IB)) i_sram_biu_top (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady), .reqCfg(reqCfg),
    .reqWrite(reqWrite), .reqFetch(reqFetch), .reqSuper(reqSuper), .reqSize(reqSize),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspValid(rspValid), .rspErr(rspErr),
    .rspRdata(rspRdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit expErr(bit cfg, bit wr, bit fe, bit su, int sz, int ad);
    int blk;
    if (cfg) return (sz != 2) || (wr && !su);
    if (sz == 3) return 1'b1;
    if (sz == 1 && (ad % 2) != 0) return 1'b1;
    if (sz == 2 && (ad % 4) != 0) return 1'b1;
    if (ad >= IB) return 1'b1;
    blk = ad / BB;
    if (wr && ctrlM[8+blk]) return 1'b1;
    if (!wr && fe && ctrlM[16+blk]) return 1'b1;
    if (!su && ctrlM[24+blk]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] expRead(int sz, int ad);
    if (sz == 0) return {24'd0, model[ad]};
    if (sz == 1) return {16'd0, model[ad+1], model[ad]};
    return {model[ad+3], model[ad+2], model[ad+1], model[ad]};
  endfunction

  // one access, waits for its response, checks error, data and latency
  task automatic acc(input string req, input bit cfg, input bit wr, input bit fe, input bit su,
                     input int sz, input int ad, input logic [31:0] wd);
    bit eErr;
    logic [31:0] eDat;
    int lat;
    int expLat;
    eErr = expErr(cfg, wr, fe, su, sz, ad);
    eDat = 32'd0;
    if (!eErr && !wr) eDat = cfg ? ctrlM : expRead(sz, ad);
    expLat = ctrlM[0] ? 2 : 1;
    @(negedge clk);
    reqValid = 1'b1; reqCfg = cfg; reqWrite = wr; reqFetch = fe; reqSuper = su;
    reqSize = 2'(sz); reqAddr = AW'(ad); reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    if (expLat == 2) begin
      chk(!reqReady && !rspValid, "R7 wait cycle", {30'd0, reqReady, rspValid}, 32'd0);
    end
    while (!rspValid && lat < 5) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == expLat, req, 32'(lat), 32'(expLat));
    chk(rspErr == eErr, req, {31'd0, rspErr}, {31'd0, eErr});
    chk(rspRdata == eDat, req, rspRdata, eDat);
    if (expLat == 2) chk(reqReady, "R7 ready in response cycle", {31'd0, reqReady}, 32'd1);
    if (!eErr && wr) begin
      if (cfg) ctrlM = wd & MASK;
      else begin
        for (int b = 0; b < (1 << sz); b++) model[ad+b] = wd[8*b +: 8];
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(reqReady && !rspValid && !rspErr, "R10 reset outputs", {29'd0, reqReady, rspValid, rspErr}, 32'd4);
    acc("R10 control reads zero after reset", 1, 0, 0, 0, 2, 0, 0);

    // R2 word fill, then byte and half overwrites, then full read sweep
    for (int a = 0; a < IB; a += 4) acc("R2 word write", 0, 1, 0, 1, 2, a, 32'(a) * 32'h0103_0507 ^ 32'hA5C3_0F96);
    for (int a = 1; a < IB; a += 5) acc("R2 byte write", 0, 1, 0, 0, 0, a, 32'hFFFF_FF00 | 32'(a * 7));
    for (int a = 2; a < IB; a += 6) acc("R2 half write", 0, 1, 0, 1, 1, a, 32'h5A5A_0000 | 32'(a * 311));
    for (int a = 0; a < IB; a++)    acc("R2 byte read", 0, 0, 0, 0, 0, a, 0);
    for (int a = 0; a < IB; a += 2) acc("R2 half read", 0, 0, 1, 1, 1, a, 0);
    for (int a = 0; a < IB; a += 4) acc("R2 word read", 0, 0, 0, 1, 2, a, 0);

    // R3 unimplemented space, including the top of the partial block
    for (int a = IB; a < (1 << AW); a += 4) acc("R3 unimplemented read", 0, 0, 0, 1, 2, a, 0);
    for (int a = IB; a < 2 * BB + BB; a++)  acc("R3 unimplemented byte write", 0, 1, 0, 1, 0, a, 32'hEE);
    acc("R3 last implemented word", 0, 0, 0, 1, 2, IB - 4, 0);

    // R9 alignment over every size and offset
    for (int sz = 0; sz < 4; sz++)
      for (int off = 0; off < 4; off++) begin
        acc("R9 aligned or not read", 0, 0, 0, 1, sz, 64 + off, 0);
        acc("R9 aligned or not write", 0, 1, 0, 1, sz, 64 + off, 32'h1234_5678);
      end
    acc("R8 memory after refused writes", 0, 0, 0, 1, 2, 64, 0);

    // R4 R5 R6 every attribute combination against every request kind
    for (int blk = 0; blk < NB; blk++)
      for (int attr = 0; attr < 8; attr++) begin
        logic [31:0] cw;
        cw = 32'd0;
        cw[8+blk] = attr[0]; cw[16+blk] = attr[1]; cw[24+blk] = attr[2];
        acc("R10 supervisor control write", 1, 1, 0, 1, 2, 0, cw);
        for (int kind = 0; kind < 8; kind++) begin
          bit wr, fe, su;
          wr = kind[0]; fe = kind[1]; su = kind[2];
          acc(wr ? "R4 protected write" : (fe ? "R5 protected fetch" : "R6 protected read"),
              0, wr, fe, su, 2, blk * BB + 8, 32'(blk * 64 + attr * 8 + kind) ^ 32'hC0DE_0000);
          acc("R8 read back after protected access", 0, 0, 0, 1, 2, blk * BB + 8, 0);
        end
      end

    // R10 control register privilege, size and undefined bits
    acc("R10 clear", 1, 1, 0, 1, 2, 0, 0);
    acc("R10 user write refused", 1, 1, 0, 0, 2, 0, 32'h0100_0000);
    acc("R10 user read allowed", 1, 0, 0, 0, 2, 12, 0);
    acc("R10 byte read refused", 1, 0, 0, 1, 0, 0, 0);
    acc("R10 half write refused", 1, 1, 0, 1, 1, 0, 32'hFFFF);
    acc("R10 all ones", 1, 1, 0, 1, 2, 0, 32'hFFFF_FFFE);
    acc("R10 undefined bits zero", 1, 0, 0, 1, 2, 0, 0);
    acc("R10 clear again", 1, 1, 0, 1, 2, 0, 0);

    // R1 back-to-back pipelined reads
    for (int i = 0; i <= 20; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk(rspValid && !rspErr, "R1 burst response", {30'd0, rspValid, rspErr}, 32'd2);
        chk(rspRdata == expRead(2, 4 * (i - 1)), "R1 burst data", rspRdata, expRead(2, 4 * (i - 1)));
      end
      chk(reqReady, "R1 ready during burst", {31'd0, reqReady}, 32'd1);
      if (i < 20) begin
        reqValid = 1'b1; reqCfg = 1'b0; reqWrite = 1'b0; reqFetch = 1'b0; reqSuper = 1'b1;
        reqSize = 2'd2; reqAddr = AW'(4 * i);
      end else reqValid = 1'b0;
    end
    @(negedge clk);
    chk(!rspValid, "R1 single response per request", {31'd0, rspValid}, 32'd0);

    // R7 two-cycle mode
    acc("R7 enter two-cycle mode", 1, 1, 0, 1, 2, 0, 32'd1);
    for (int a = 0; a < IB; a += 12) acc("R7 slow word read", 0, 0, 0, 1, 2, a, 0);
    for (int a = 3; a < IB; a += 17) acc("R7 slow byte write", 0, 1, 0, 0, 0, a, 32'(a));
    for (int a = 0; a < IB; a += 9)  acc("R7 slow byte read", 0, 0, 1, 0, 0, a, 0);
    acc("R7 slow unimplemented", 0, 0, 0, 1, 2, IB, 0);
    acc("R7 slow protect set", 1, 1, 0, 1, 2, 0, 32'h0000_0201);
    acc("R4 slow write refused", 0, 1, 0, 1, 2, BB + 4, 32'hDEAD_BEEF);
    acc("R8 slow read back", 0, 0, 0, 1, 2, BB + 4, 0);
    acc("R7 back to one-cycle", 1, 1, 0, 1, 2, 0, 32'd0);
    acc("R1 one-cycle again", 0, 0, 0, 1, 2, 8, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule